// File: doc/BRIEF.md
# Two-Channel DC Offset Successive-Approximation Calibrator

This block computes correction codes for a pair of offset-cancelling DACs, one on the in-phase path and one on the quadrature path. An external detector reports one sign bit per channel. The bit says whether that channel's output offset still needs more correction. Both channels are resolved at the same time by a binary search that starts from mid-scale. The search tests one code bit per calibration step, from the most significant bit down. After the last bit there is one further step that closes the run.

The calibration steps are paced by a clock-enable pulse generated in the system clock domain. The source of this pulse is selectable: either a tick from an internal oscillator or a tick taken from the serial programming clock. The pulse rate is then divided by a ratio picked from an eight-entry table. The two code registers drive the DACs directly. Three operations can change them: a calibration reset sets them to mid-scale, a manual override copies software-supplied codes into them, and an accepted automatic run overwrites them. Control pins are plain levels and pulses. There is no streaming interface and no back-pressure.

Top module: `dcofs_sar_cal`

## Requirements
- R1: After rst_n and after any cycle with cal_rst high, both codes read 128 (binary 1000_0000), and busy and done are 0. cal_rst also aborts a running search.
- R2: A start pulse is accepted only when auto_mode=1 and bsearch_en=1. In any other mode, start leaves busy low and leaves the codes unchanged.
- R3: busy rises in the cycle after an accepted start and stays high until the run completes. done rises as busy falls and stays high until the next accepted start or cal_rst. busy and done are never both high.
- R4: Each run starts with code 128. On calibration steps 1 to 8 the current trial bit (bit 7 first, then bit 6, down to bit 0) is kept if that channel's sign input is 1 and cleared if it is 0. The next lower bit is then set as the new trial. With a detector that reports 1 while code <= target, the final code equals the target, for every target from 0 to 255.
- R5: A run takes exactly nine calibration steps. With the source tick present every cycle and a ratio N, done is first seen 9*N cycles after the edge that accepted the start.
- R6: div_sel selects the ratio of source ticks per calibration step: 0→1, 1→8, 2→16, 3→128, 4→256, 5→1024, 6→2048, 7→16384.
- R7: clk_src_sel=1 paces steps from osc_tick only. clk_src_sel=0 paces steps from sclk_tick only. The unselected tick has no effect on progress.
- R8: Once a run has finished, both codes hold their values even if the sign inputs change, until cal_rst or a new accepted start.
- R9: When auto_mode=0 and bsearch_en=0 and no run is active, man_code_i and man_code_q appear on code_i and code_q one cycle later. In the other modes the manual fields have no effect.
- R10: A start pulse arriving while busy is ignored. The run in progress keeps both its result and its duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle tick from the internal oscillator, already in the clk domain |
| sclk_tick | input | 1 | One-cycle tick derived from the serial clock, already in the clk domain |
| clk_src_sel | input | 1 | 1 selects osc_tick, 0 selects sclk_tick |
| div_sel | input | 3 | Divider ratio select |
| auto_mode | input | 1 | Automatic correction mode |
| bsearch_en | input | 1 | Binary-search enable |
| start | input | 1 | Calibration start request |
| cal_rst | input | 1 | Synchronous calibration reset |
| man_code_i | input | 8 | Manual I-channel code |
| man_code_q | input | 8 | Manual Q-channel code |
| sign_i | input | 1 | I detector: 1 means more correction is needed |
| sign_q | input | 1 | Q detector: 1 means more correction is needed |
| code_i | output | 8 | I-channel DAC code |
| code_q | output | 8 | Q-channel DAC code |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has completed |

## Verification
The bench instantiates the block with its default CODE_W of 8 and the full eight-entry ratio table. Divider selects 0 to 4 are timed end to end, so step counting is checked at both unit and large ratios within the cycle budget. The 8-bit code width lets the extreme targets 0 and 255 be reached, along with mid-scale and irregular targets. The I and Q channels are driven with different targets in the same run, which exposes any crossover between them.

// File: rtl/dcofs_pkg.sv
package dcofs_pkg;
  localparam int unsigned DIV_SEL_W = 3;
  localparam int unsigned MAX_RATIO = 16384;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

  typedef enum logic [0:0] {SRC_SERIAL = 1'b0, SRC_OSC = 1'b1} src_sel_e;

  function automatic int unsigned div_ratio(input logic [DIV_SEL_W-1:0] sel);
    case (sel)
      3'd0: div_ratio = 1;
      3'd1: div_ratio = 8;
      3'd2: div_ratio = 16;
      3'd3: div_ratio = 128;
      3'd4: div_ratio = 256;
      3'd5: div_ratio = 1024;
      3'd6: div_ratio = 2048;
      default: div_ratio = MAX_RATIO;
    endcase
  endfunction
endpackage

// File: rtl/dcofs_tick_gen.sv
module dcofs_tick_gen
  import dcofs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 osc_tick,
  input  logic                 sclk_tick,
  input  logic                 src_sel,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 cal_en
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             src_tick;

  assign src_tick = (src_sel == SRC_OSC) ? osc_tick : sclk_tick;
  assign lim      = CNT_W'(div_ratio(div_sel) - 1);
  assign cal_en   = src_tick && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (src_tick) cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_tick && !restart) |=> $stable(cnt_q)); // R6
  AST_SRC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_sel && !osc_tick) || (!src_sel && !sclk_tick)) |-> !cal_en); // R7
endmodule

// File: rtl/dcofs_sar_chan.sv
module dcofs_sar_chan #(
  parameter int CODE_W = 8,
  localparam int IDX_W = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              init,
  input  logic              step_en,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              sign,
  input  logic              man_load,
  input  logic [CODE_W-1:0] man_code,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] code_q, stepped;

  always_comb begin
    stepped = code_q;
    stepped[bit_idx] = sign;
    if (bit_idx != '0) stepped[bit_idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= MID;
    else if (clr)      code_q <= MID;
    else if (init)     code_q <= MID;
    else if (step_en)  code_q <= stepped;
    else if (man_load) code_q <= man_code;
  end

  assign code = code_q;

  AST_CLR_MID: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (code_q == MID)); // R1
  AST_STEP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !clr && !init) |=> (code_q[$past(bit_idx)] == $past(sign))); // R4
endmodule

// File: rtl/dcofs_sar_cal.sv
module dcofs_sar_cal
  import dcofs_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              sclk_tick,
  input  logic              clk_src_sel,
  input  logic [2:0]        div_sel,
  input  logic              auto_mode,
  input  logic              bsearch_en,
  input  logic              start,
  input  logic              cal_rst,
  input  logic [CODE_W-1:0] man_code_i,
  input  logic [CODE_W-1:0] man_code_q,
  input  logic              sign_i,
  input  logic              sign_q,
  output logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_q,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W  = $clog2(CODE_W);
  localparam int STEP_W = $clog2(CODE_W + 2);
  localparam int NCH    = 2;

  logic              busy_q, done_q, cal_en, start_ok, final_step, man_load, step_en;
  logic [STEP_W-1:0] step_q;
  logic [IDX_W-1:0]  bit_idx;
  logic [NCH-1:0]    signs;
  logic [CODE_W-1:0] man_codes [NCH];
  logic [CODE_W-1:0] codes     [NCH];

  assign start_ok   = start && auto_mode && bsearch_en && !busy_q && !cal_rst;
  assign final_step = (step_q == STEP_W'(CODE_W));
  assign step_en    = busy_q && cal_en && !final_step && !cal_rst;
  assign bit_idx    = IDX_W'(CODE_W - 1) - IDX_W'(step_q);
  assign man_load   = !auto_mode && !bsearch_en && !busy_q;
  assign signs      = {sign_q, sign_i};
  assign man_codes[0] = man_code_i;
  assign man_codes[1] = man_code_q;

  dcofs_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .restart(start_ok),
    .osc_tick(osc_tick), .sclk_tick(sclk_tick),
    .src_sel(clk_src_sel), .div_sel(div_sel), .cal_en(cal_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; step_q <= '0;
    end else if (cal_rst) begin
      busy_q <= 1'b0; done_q <= 1'b0; step_q <= '0;
    end else if (start_ok) begin
      busy_q <= 1'b1; done_q <= 1'b0; step_q <= '0;
    end else if (busy_q && cal_en) begin
      if (final_step) begin
        busy_q <= 1'b0; done_q <= 1'b1; step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    dcofs_sar_chan #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .clr(cal_rst), .init(start_ok),
      .step_en(step_en), .bit_idx(bit_idx), .sign(signs[ch]),
      .man_load(man_load), .man_code(man_codes[ch]), .code(codes[ch])
    );
  end

  assign code_i = codes[0];
  assign code_q = codes[1];
  assign busy   = busy_q;
  assign done   = done_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q)); // R3
  AST_CALRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_rst |=> (!busy_q && !done_q)); // R1
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !(auto_mode && bsearch_en)) |=> !busy_q); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_ok && !cal_rst && !man_load) |=> ($stable(code_i) && $stable(code_q))); // R8
  AST_MANUAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (man_load && !cal_rst) |=> (code_i == $past(man_code_i) && code_q == $past(man_code_q))); // R9
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(CODE_W)); // R5
endmodule

// File: tb/sim_dcofs_sar_cal.sv
module sim_dcofs_sar_cal;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, sclk_tick = 1'b0, clk_src_sel = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic auto_mode = 1'b1, bsearch_en = 1'b1, start = 1'b0, cal_rst = 1'b0;
  logic [7:0] man_code_i = 8'h00, man_code_q = 8'h00;
  logic [7:0] tgt_i = 8'd0, tgt_q = 8'd0;
  logic sign_i, sign_q;
  logic [7:0] code_i, code_q;
  logic busy, done;
  logic osc_on = 1'b0;
  int osc_ph = 0;
  int errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  assign sign_i = (code_i <= tgt_i);
  assign sign_q = (code_q <= tgt_q);

  always @(negedge clk) begin
    osc_ph = (osc_ph == 2) ? 0 : osc_ph + 1;
    osc_tick = osc_on && (osc_ph == 0);
  end

  dcofs_sar_cal u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sclk_tick(sclk_tick),
    .clk_src_sel(clk_src_sel), .div_sel(div_sel), .auto_mode(auto_mode),
    .bsearch_en(bsearch_en), .start(start), .cal_rst(cal_rst),
    .man_code_i(man_code_i), .man_code_q(man_code_q), .sign_i(sign_i), .sign_q(sign_q),
    .code_i(code_i), .code_q(code_q), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // counts edges after the accepting edge until done is seen
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk(code_i == 8'd128, "R1 reset code_i", code_i, 128);
    chk(code_q == 8'd128, "R1 reset code_q", code_q, 128);
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
  endtask

  task automatic t_search(input logic [7:0] ti, input logic [7:0] tq, input logic [2:0] ds, input int exp_n);
    int n;
    auto_mode = 1; bsearch_en = 1; clk_src_sel = 0; sclk_tick = 1;
    div_sel = ds; tgt_i = ti; tgt_q = tq;
    pulse_start();
    chk(busy, "R3 busy after start", busy, 1);
    wait_done(n);
    chk(n == exp_n, "R5/R6 run length", n, exp_n);
    chk(code_i == ti, "R4 result I", code_i, ti);
    chk(code_q == tq, "R4 result Q", code_q, tq);
    chk(!busy && done, "R3 done level", {busy, done}, 1);
  endtask

  task automatic t_mode_ignore();
    logic [7:0] ci;
    ci = code_i;
    auto_mode = 1; bsearch_en = 0;
    pulse_start();
    chk(!busy, "R2 start ignored bsearch_en=0", busy, 0);
    auto_mode = 0; bsearch_en = 1;
    pulse_start();
    chk(!busy, "R2 start ignored auto_mode=0", busy, 0);
    chk(code_i == ci, "R2 code unchanged", code_i, ci);
    auto_mode = 1; bsearch_en = 1;
  endtask

  task automatic t_busy_start();
    int n;
    auto_mode = 1; bsearch_en = 1; clk_src_sel = 0; sclk_tick = 1;
    div_sel = 3'd1; tgt_i = 8'd201; tgt_q = 8'd14;
    pulse_start();
    repeat (20) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    n = 21;
    while (!done && n < 40000) begin @(negedge clk); n++; end
    chk(n == 72, "R10 duration with extra start", n, 72);
    chk(code_i == 8'd201 && code_q == 8'd14, "R10 result with extra start", code_i, 201);
  endtask

  task automatic t_hold();
    logic [7:0] ci, cq;
    ci = code_i; cq = code_q;
    tgt_i = ~tgt_i; tgt_q = ~tgt_q;
    repeat (25) @(negedge clk);
    chk(code_i == ci && code_q == cq, "R8 codes held", code_i, ci);
    chk(done, "R3 done held", done, 1);
  endtask

  task automatic t_clk_sel();
    int n;
    clk_src_sel = 1; sclk_tick = 1; osc_on = 0; div_sel = 0;
    tgt_i = 8'd37; tgt_q = 8'd250;
    pulse_start();
    repeat (30) @(negedge clk);
    chk(busy, "R7 no progress from serial tick", busy, 1);
    chk(code_i == 8'd128 && code_q == 8'd128, "R7 codes untouched", code_i, 128);
    osc_on = 1; sclk_tick = 0;
    wait_done(n);
    chk(code_i == 8'd37 && code_q == 8'd250, "R7 osc paced result", code_q, 250);
    osc_on = 0; clk_src_sel = 0; sclk_tick = 1;
  endtask

  task automatic t_abort();
    div_sel = 3'd1; tgt_i = 8'd3; tgt_q = 8'd99;
    pulse_start();
    repeat (20) @(negedge clk);
    cal_rst = 1; @(negedge clk); cal_rst = 0;
    chk(!busy && !done, "R1 abort clears busy/done", {busy, done}, 0);
    chk(code_i == 8'd128 && code_q == 8'd128, "R1 abort mid-scale", code_i, 128);
  endtask

  task automatic t_manual();
    man_code_i = 8'h3C; man_code_q = 8'hA5;
    repeat (3) @(negedge clk);
    chk(code_i == 8'd128, "R9 manual ignored in auto", code_i, 128);
    auto_mode = 0; bsearch_en = 0;
    @(negedge clk);
    chk(code_i == 8'h3C && code_q == 8'hA5, "R9 manual load", code_q, 8'hA5);
    man_code_i = 8'h01;
    @(negedge clk);
    chk(code_i == 8'h01, "R9 manual follows", code_i, 1);
    auto_mode = 1; bsearch_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_search(8'd128, 8'd77, 3'd0, 9);
    t_search(8'd0, 8'd255, 3'd1, 72);
    t_search(8'd255, 8'd0, 3'd2, 144);
    t_search(8'd90, 8'd161, 3'd3, 1152);
    t_search(8'd7, 8'd200, 3'd4, 2304);
    t_hold();
    t_mode_ignore();
    t_busy_start();
    t_clk_sel();
    t_abort();
    t_manual();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule